// File: doc/BRIEF.md
# Interrupt Stack Frame Sequencer

This block turns one interrupt or exception delivery into the stack traffic and register updates it causes. On a start pulse it takes a snapshot of the gate (type, selector, offset), the interrupted context (CS, instruction pointer, flags, SS, stack pointer, privilege level), the virtual-8086 flag, the protected-mode enable, the per-ring stack entries from the task state segment and an optional error code. From these it decides whether the stack must change and how wide each push is. It then walks an ordered list of pushes over a single-beat memory write port with a request/acknowledge handshake.

When the last push has been acknowledged, the block raises a one-cycle completion pulse. At that point its outputs carry the new CS, instruction pointer, SS, stack pointer, privilege level, interrupt-enable and virtual-8086 values, and a flag that tells the core to load null selectors into the four data segments. A protected-mode task gate is not executed here: the block only raises a one-cycle request for the task-switch logic. Descriptor validity checks belong to the caller.

Top module: `intr_frame_seq`

## Requirements
- R1: A start pulse is taken only while `busy` is low, and all inputs are captured at that edge. A start pulse during a running delivery has no effect, and later input changes do not alter the frame in progress.
- R2: In protected mode the gate type codes are 5 = task gate, 6 = 16-bit interrupt gate, 7 = 16-bit trap gate, 14 = 32-bit interrupt gate and 15 = 32-bit trap gate. Any other code behaves as a 16-bit trap gate. A task gate produces one `task_req` pulse, no memory write and no `done`.
- R3: In protected mode the stack changes when the current privilege level is greater than gate_sel[1:0] (the requested level), or when the virtual-8086 flag is set. The new privilege level is then gate_sel[1:0], and the new SS and stack pointer are entry gate_sel[1:0] of the ring buses (entry g at bits [g*16 +: 16] of `ring_ss_bus` and [g*32 +: 32] of `ring_sp_bus`). Level 3 has no entry and keeps the current SS and stack pointer. Without a stack change, the SS, stack pointer and privilege level keep their current values.
- R4: Protected-mode entry with the virtual-8086 flag set first pushes GS, FS, DS and ES, in that order. It then reports `segs_null` = 1 and `new_vm` = 0. Otherwise `segs_null` is 0.
- R5: After a stack change, the old SS and then the old stack pointer are pushed, onto the new stack.
- R6: Next come the old flags, the old CS and the old instruction pointer, in that order. The error code follows only when `err_push` is set and protected mode is on.
- R7: Pushes are 32 bits wide for gate codes 14 and 15 and 16 bits wide otherwise, with `wr_wide` = 1 for 32 bits. A 16-bit push carries the low half of the value, zero-extended. Every push first lowers the stack pointer by 2 or 4 and writes at the lowered value. `new_sp` ends at the last address written.
- R8: A 32-bit gate loads the whole offset into the instruction pointer. Any other delivery replaces only bits [15:0] and keeps bits [31:16] of the current instruction pointer. `new_cs` is the gate selector in protected mode.
- R9: In real mode the vector entry supplies offset = vec_entry[15:0] and CS = vec_entry[31:16]. The delivery behaves as a present 16-bit interrupt gate: no stack change, and only flags, CS and the instruction pointer are pushed.
- R10: `new_if` is 0 after an interrupt gate (codes 6 and 14) and after any real-mode delivery. Otherwise it equals bit 9 of the captured flags.
- R11: `wr_req` stays high with stable address, data and width until `wr_ack` is seen high at a clock edge. Each acknowledged edge retires exactly one push.
- R12: `done` is a single-cycle pulse in the cycle after the last acknowledged push. All `new_*` outputs are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a delivery (taken when idle) |
| prot_en | input | 1 | Protected mode enabled |
| vm_flag | input | 1 | Virtual-8086 flag of the interrupted context |
| gate_type | input | 4 | Gate type code |
| gate_sel | input | 16 | Gate target selector |
| gate_off | input | 32 | Gate target offset |
| vec_entry | input | 32 | Real-mode vector entry {CS, offset} |
| cur_cs | input | 16 | Current CS selector |
| cur_ip | input | 32 | Current instruction pointer |
| cur_flags | input | 32 | Current flags |
| cur_ss | input | 16 | Current SS selector |
| cur_sp | input | 32 | Current stack pointer |
| cur_cpl | input | 2 | Current privilege level |
| seg_gs | input | 16 | Current GS selector |
| seg_fs | input | 16 | Current FS selector |
| seg_ds | input | 16 | Current DS selector |
| seg_es | input | 16 | Current ES selector |
| ring_ss_bus | input | 48 | Stack selectors for rings 0..2 |
| ring_sp_bus | input | 96 | Stack pointers for rings 0..2 |
| err_code | input | 32 | Error code value |
| err_push | input | 1 | The exception carries an error code |
| wr_ack | input | 1 | Write accepted |
| busy | output | 1 | Delivery in progress |
| wr_req | output | 1 | Write request |
| wr_wide | output | 1 | Write is 32 bits (else 16) |
| wr_addr | output | 32 | Stack offset of the write |
| wr_data | output | 32 | Write data |
| done | output | 1 | Delivery finished (one cycle) |
| task_req | output | 1 | Task-gate switch requested (one cycle) |
| new_cs | output | 16 | CS to load |
| new_ip | output | 32 | Instruction pointer to load |
| new_ss | output | 16 | SS to load |
| new_sp | output | 32 | Final stack pointer |
| new_cpl | output | 2 | New privilege level |
| new_if | output | 1 | New interrupt-enable flag |
| new_vm | output | 1 | New virtual-8086 flag |
| segs_null | output | 1 | Load null into GS, FS, DS and ES |

## Verification
Two events can land on the same clock edge: a fresh start request and the acknowledgement that retires a push of the delivery already running. The bench raises `start` with a scrambled gate and context in a cycle where a write is being acknowledged. It then judges the outcome by comparing the rest of the frame and the final `new_*` outputs against the frame predicted from the original snapshot. Zero-wait acknowledges, taken in the same cycle the request appears, also coincide with the step to the next enabled push. Acknowledge latencies of 0 to 2 cycles are rotated across the sweep so that these edges get covered.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam logic [3:0] GT_TASK   = 4'd5;
  localparam logic [3:0] GT_INT16  = 4'd6;
  localparam logic [3:0] GT_TRAP16 = 4'd7;
  localparam logic [3:0] GT_INT32  = 4'd14;
  localparam logic [3:0] GT_TRAP32 = 4'd15;

  localparam int IF_BIT = 9;

  // push slots in stack order
  localparam int SL_GS = 0;
  localparam int SL_FS = 1;
  localparam int SL_DS = 2;
  localparam int SL_ES = 3;
  localparam int SL_SS = 4;
  localparam int SL_SP = 5;
  localparam int SL_FL = 6;
  localparam int SL_CS = 7;
  localparam int SL_IP = 8;
  localparam int SL_EC = 9;
  localparam int NSLOT = 10;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PUSH = 2'd1,
    S_DONE = 2'd2,
    S_TASK = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ifs_gate_decode.sv
module ifs_gate_decode
  import ifs_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic            prot_en,
  input  logic            vm_flag,
  input  logic [3:0]      gate_type,
  input  logic [SW-1:0]   gate_sel,
  input  logic [DW-1:0]   gate_off,
  input  logic [2*SW-1:0] vec_entry,
  input  logic [DW-1:0]   cur_ip,
  input  logic [1:0]      cur_cpl,
  input  logic            cur_if,
  input  logic            err_push,
  output logic            is_task,
  output logic            wide,
  output logic            do_switch,
  output logic            vm_entry,
  output logic            err_en,
  output logic [1:0]      tgt_cpl,
  output logic [SW-1:0]   tgt_cs,
  output logic [DW-1:0]   tgt_ip,
  output logic            tgt_if
);
  logic [1:0]    rpl;
  logic          is_int;
  logic [DW-1:0] off;

  always_comb begin
    rpl       = gate_sel[1:0];
    is_task   = prot_en && (gate_type == GT_TASK);
    wide      = prot_en && ((gate_type == GT_INT32) || (gate_type == GT_TRAP32));
    is_int    = !prot_en || (gate_type == GT_INT16) || (gate_type == GT_INT32);
    do_switch = prot_en && !is_task && ((cur_cpl > rpl) || vm_flag);
    vm_entry  = prot_en && !is_task && vm_flag;
    err_en    = prot_en && err_push;
    tgt_cpl   = do_switch ? rpl : cur_cpl;
    tgt_cs    = prot_en ? gate_sel : vec_entry[2*SW-1:SW];
    off       = prot_en ? gate_off : {{(DW-SW){1'b0}}, vec_entry[SW-1:0]};
    tgt_ip    = wide ? off : {cur_ip[DW-1:16], off[15:0]};
    tgt_if    = is_int ? 1'b0 : cur_if;
  end
endmodule

// File: rtl/ifs_ring_select.sv
module ifs_ring_select #(
  parameter int DW    = 32,
  parameter int SW    = 16,
  parameter int NRING = 3
) (
  input  logic                use_ring,
  input  logic [1:0]          ring,
  input  logic [NRING*SW-1:0] ring_ss_bus,
  input  logic [NRING*DW-1:0] ring_sp_bus,
  input  logic [SW-1:0]       cur_ss,
  input  logic [DW-1:0]       cur_sp,
  output logic [SW-1:0]       sel_ss,
  output logic [DW-1:0]       sel_sp
);
  logic [NRING-1:0] hit;

  for (genvar g = 0; g < NRING; g++) begin : g_hit
    assign hit[g] = use_ring && (ring == 2'(g));
  end

  always_comb begin
    sel_ss = cur_ss;
    sel_sp = cur_sp;
    for (int i = 0; i < NRING; i++) begin
      if (hit[i]) begin
        sel_ss = ring_ss_bus[i*SW +: SW];
        sel_sp = ring_sp_bus[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/ifs_push_seq.sv
module ifs_push_seq
  import ifs_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SLW = $clog2(NSLOT + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      load_task,
  input  logic                      load_wide,
  input  logic [NSLOT-1:0]          load_mask,
  input  logic [NSLOT-1:0][DW-1:0]  load_vals,
  input  logic [DW-1:0]             load_sp,
  input  logic                      wr_ack,
  output logic                      busy,
  output logic                      wr_req,
  output logic                      wr_wide,
  output logic [DW-1:0]             wr_addr,
  output logic [DW-1:0]             wr_data,
  output logic                      done,
  output logic                      task_req,
  output logic [DW-1:0]             sp_out
);
  seq_state_t              st_q, st_d;
  logic [SLW-1:0]          step_q, step_d;
  logic [DW-1:0]           sp_q, sp_d;
  logic [NSLOT-1:0]        mask_q;
  logic [NSLOT-1:0][DW-1:0] vals_q;
  logic                    wide_q;
  logic [DW-1:0]           push_addr;
  logic [DW-1:0]           cur_val;

  function automatic logic [SLW-1:0] first_from(input logic [NSLOT-1:0] m,
                                                input logic [SLW-1:0] from);
    logic [SLW-1:0] r;
    logic found;
    r = SLW'(NSLOT);
    found = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!found && (SLW'(i) >= from) && m[i]) begin
        r = SLW'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    push_addr = sp_q - (wide_q ? DW'(4) : DW'(2));
    cur_val   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (step_q == SLW'(i)) cur_val = vals_q[i];
    end
  end

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    sp_d   = sp_q;
    case (st_q)
      S_IDLE: begin
        if (load) begin
          sp_d = load_sp;
          if (load_task) begin
            st_d = S_TASK;
          end else begin
            step_d = first_from(load_mask, '0);
            st_d   = (step_d == SLW'(NSLOT)) ? S_DONE : S_PUSH;
          end
        end
      end
      S_PUSH: begin
        if (wr_ack) begin
          sp_d   = push_addr;
          step_d = first_from(mask_q, step_q + SLW'(1));
          if (step_d == SLW'(NSLOT)) st_d = S_DONE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      sp_q   <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      sp_q   <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      vals_q <= '0;
      wide_q <= 1'b0;
    end else if (load && (st_q == S_IDLE)) begin
      mask_q <= load_mask;
      vals_q <= load_vals;
      wide_q <= load_wide;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign wr_req   = (st_q == S_PUSH);
  assign wr_wide  = wide_q;
  assign wr_addr  = push_addr;
  assign wr_data  = wide_q ? cur_val : {{(DW-16){1'b0}}, cur_val[15:0]};
  assign done     = (st_q == S_DONE);
  assign task_req = (st_q == S_TASK);
  assign sp_out   = sp_q;
endmodule

// File: rtl/intr_frame_seq.sv
module intr_frame_seq
  import ifs_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SW    = 16,
  parameter int NRING = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                prot_en,
  input  logic                vm_flag,
  input  logic [3:0]          gate_type,
  input  logic [SW-1:0]       gate_sel,
  input  logic [DW-1:0]       gate_off,
  input  logic [2*SW-1:0]     vec_entry,
  input  logic [SW-1:0]       cur_cs,
  input  logic [DW-1:0]       cur_ip,
  input  logic [DW-1:0]       cur_flags,
  input  logic [SW-1:0]       cur_ss,
  input  logic [DW-1:0]       cur_sp,
  input  logic [1:0]          cur_cpl,
  input  logic [SW-1:0]       seg_gs,
  input  logic [SW-1:0]       seg_fs,
  input  logic [SW-1:0]       seg_ds,
  input  logic [SW-1:0]       seg_es,
  input  logic [NRING*SW-1:0] ring_ss_bus,
  input  logic [NRING*DW-1:0] ring_sp_bus,
  input  logic [DW-1:0]       err_code,
  input  logic                err_push,
  input  logic                wr_ack,
  output logic                busy,
  output logic                wr_req,
  output logic                wr_wide,
  output logic [DW-1:0]       wr_addr,
  output logic [DW-1:0]       wr_data,
  output logic                done,
  output logic                task_req,
  output logic [SW-1:0]       new_cs,
  output logic [DW-1:0]       new_ip,
  output logic [SW-1:0]       new_ss,
  output logic [DW-1:0]       new_sp,
  output logic [1:0]          new_cpl,
  output logic                new_if,
  output logic                new_vm,
  output logic                segs_null
);
  localparam int PADW = DW - SW;

  logic                     accept;
  logic                     is_task, wide, do_switch, vm_entry, err_en, tgt_if;
  logic [1:0]               tgt_cpl;
  logic [SW-1:0]            tgt_cs, sel_ss;
  logic [DW-1:0]            tgt_ip, sel_sp;
  logic [NSLOT-1:0]         mask;
  logic [NSLOT-1:0][DW-1:0] vals;

  logic [SW-1:0] cs_q, ss_q;
  logic [DW-1:0] ip_q;
  logic [1:0]    cpl_q;
  logic          if_q, vm_q, null_q;

  assign accept = start && !busy;

  ifs_gate_decode #(.DW(DW), .SW(SW)) u_dec (
    .prot_en  (prot_en),
    .vm_flag  (vm_flag),
    .gate_type(gate_type),
    .gate_sel (gate_sel),
    .gate_off (gate_off),
    .vec_entry(vec_entry),
    .cur_ip   (cur_ip),
    .cur_cpl  (cur_cpl),
    .cur_if   (cur_flags[IF_BIT]),
    .err_push (err_push),
    .is_task  (is_task),
    .wide     (wide),
    .do_switch(do_switch),
    .vm_entry (vm_entry),
    .err_en   (err_en),
    .tgt_cpl  (tgt_cpl),
    .tgt_cs   (tgt_cs),
    .tgt_ip   (tgt_ip),
    .tgt_if   (tgt_if)
  );

  ifs_ring_select #(.DW(DW), .SW(SW), .NRING(NRING)) u_ring (
    .use_ring   (do_switch),
    .ring       (gate_sel[1:0]),
    .ring_ss_bus(ring_ss_bus),
    .ring_sp_bus(ring_sp_bus),
    .cur_ss     (cur_ss),
    .cur_sp     (cur_sp),
    .sel_ss     (sel_ss),
    .sel_sp     (sel_sp)
  );

  always_comb begin
    mask        = '0;
    mask[SL_GS] = vm_entry;
    mask[SL_FS] = vm_entry;
    mask[SL_DS] = vm_entry;
    mask[SL_ES] = vm_entry;
    mask[SL_SS] = do_switch;
    mask[SL_SP] = do_switch;
    mask[SL_FL] = 1'b1;
    mask[SL_CS] = 1'b1;
    mask[SL_IP] = 1'b1;
    mask[SL_EC] = err_en;

    vals        = '0;
    vals[SL_GS] = {{PADW{1'b0}}, seg_gs};
    vals[SL_FS] = {{PADW{1'b0}}, seg_fs};
    vals[SL_DS] = {{PADW{1'b0}}, seg_ds};
    vals[SL_ES] = {{PADW{1'b0}}, seg_es};
    vals[SL_SS] = {{PADW{1'b0}}, cur_ss};
    vals[SL_SP] = cur_sp;
    vals[SL_FL] = cur_flags;
    vals[SL_CS] = {{PADW{1'b0}}, cur_cs};
    vals[SL_IP] = cur_ip;
    vals[SL_EC] = err_code;
  end

  ifs_push_seq #(.DW(DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_task(is_task),
    .load_wide(wide),
    .load_mask(mask),
    .load_vals(vals),
    .load_sp  (sel_sp),
    .wr_ack   (wr_ack),
    .busy     (busy),
    .wr_req   (wr_req),
    .wr_wide  (wr_wide),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (done),
    .task_req (task_req),
    .sp_out   (new_sp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '0;
      ss_q   <= '0;
      ip_q   <= '0;
      cpl_q  <= '0;
      if_q   <= 1'b0;
      vm_q   <= 1'b0;
      null_q <= 1'b0;
    end else if (accept) begin
      cs_q   <= tgt_cs;
      ss_q   <= sel_ss;
      ip_q   <= tgt_ip;
      cpl_q  <= tgt_cpl;
      if_q   <= tgt_if;
      vm_q   <= prot_en ? 1'b0 : vm_flag;
      null_q <= vm_entry;
    end
  end

  assign new_cs    = cs_q;
  assign new_ss    = ss_q;
  assign new_ip    = ip_q;
  assign new_cpl   = cpl_q;
  assign new_if    = if_q;
  assign new_vm    = vm_q;
  assign segs_null = null_q;
endmodule

// File: rtl/ifs_checker.sv
module ifs_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          wr_req,
  input logic          wr_ack,
  input logic          wr_wide,
  input logic [DW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          done,
  input logic          task_req,
  input logic [DW-1:0] new_sp
);
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_req_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> busy);

  p_task_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    task_req |-> !wr_req && !done);

  p_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_wide |-> wr_data[DW-1:16] == '0);

  p_sp_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack |=> new_sp == $past(wr_addr));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_wide));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind intr_frame_seq ifs_checker #(.DW(DW)) u_ifs_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .wr_req  (wr_req),
  .wr_ack  (wr_ack),
  .wr_wide (wr_wide),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .done    (done),
  .task_req(task_req),
  .new_sp  (new_sp)
);

// File: tb/intr_frame_seq_test.sv
module intr_frame_seq_test;
  logic        clk, rst_n, start, prot_en, vm_flag, err_push, wr_ack;
  logic [3:0]  gate_type;
  logic [15:0] gate_sel, cur_cs, cur_ss, seg_gs, seg_fs, seg_ds, seg_es;
  logic [31:0] gate_off, vec_entry, cur_ip, cur_flags, cur_sp, err_code;
  logic [1:0]  cur_cpl;
  logic [47:0] ring_ss_bus;
  logic [95:0] ring_sp_bus;
  logic        busy, wr_req, wr_wide, done, task_req, new_if, new_vm, segs_null;
  logic [31:0] wr_addr, wr_data, new_ip, new_sp;
  logic [15:0] new_cs, new_ss;
  logic [1:0]  new_cpl;

  int n_chk = 0;
  int n_fail = 0;

  intr_frame_seq uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] ex_addr [10];
  logic [31:0] ex_data [10];
  string       ex_tag  [10];
  int          nexp;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic p, input logic [3:0] t, input logic v,
                           input logic [1:0] cpl, input logic [1:0] rpl,
                           input logic ep, input logic [31:0] fl, input int seed,
                           input logic disturb);
    logic        is_task, wide, sw, is_int;
    logic [31:0] sp, sz, off, e_ip;
    logic [15:0] e_ss, e_cs;
    logic [1:0]  e_cpl;
    logic [31:0] vals [10];
    string       tags [10];
    int          n, idx, wcnt, cyc;
    logic        got_done, got_task;
    @(negedge clk);
    prot_en = p; gate_type = t; vm_flag = v; cur_cpl = cpl; err_push = ep;
    gate_sel = {14'h0A5C >> 0, rpl} ^ 16'h0000;
    gate_sel = {14'h1A5C, rpl};
    gate_off = 32'hC0DE_0000 + 32'(seed * 16);
    vec_entry = {16'h7000 + 16'(seed), 16'h0100 + 16'(seed)};
    cur_cs = 16'h2B3B; cur_ip = 32'h4567_89AB + 32'(seed); cur_flags = fl;
    cur_ss = 16'h0FF3; cur_sp = 32'h0000_8000;
    seg_gs = 16'h1111; seg_fs = 16'h2222; seg_ds = 16'h3333; seg_es = 16'h4444;
    err_code = 32'hEE00_0000 + 32'(seed);
    // expected model
    is_task = p && (t == 4'd5);
    wide    = p && (t == 4'd14 || t == 4'd15);
    is_int  = !p || t == 4'd6 || t == 4'd14;
    sw      = p && !is_task && ((cpl > rpl) || v);
    e_ss = cur_ss; sp = cur_sp; e_cpl = cpl;
    if (sw) begin
      e_cpl = rpl;
      if (rpl != 2'd3) begin
        e_ss = ring_ss_bus[rpl*16 +: 16];
        sp   = ring_sp_bus[rpl*32 +: 32];
      end
    end
    n = 0;
    if (p && !is_task && v) begin
      vals[n] = 32'(seg_gs); tags[n] = "R4"; n++;
      vals[n] = 32'(seg_fs); tags[n] = "R4"; n++;
      vals[n] = 32'(seg_ds); tags[n] = "R4"; n++;
      vals[n] = 32'(seg_es); tags[n] = "R4"; n++;
    end
    if (sw) begin
      vals[n] = 32'(cur_ss); tags[n] = "R5"; n++;
      vals[n] = cur_sp;      tags[n] = "R5"; n++;
    end
    vals[n] = fl;             tags[n] = p ? "R6" : "R9"; n++;
    vals[n] = 32'(cur_cs);    tags[n] = p ? "R6" : "R9"; n++;
    vals[n] = cur_ip;         tags[n] = p ? "R6" : "R9"; n++;
    if (p && ep) begin vals[n] = err_code; tags[n] = "R6"; n++; end
    if (is_task) n = 0;
    sz = wide ? 32'd4 : 32'd2;
    for (int i = 0; i < n; i++) begin
      sp = sp - sz;
      ex_addr[i] = sp;
      ex_data[i] = wide ? vals[i] : {16'h0, vals[i][15:0]};
      ex_tag[i]  = tags[i];
    end
    nexp = n;
    e_cs = p ? gate_sel : vec_entry[31:16];
    off  = p ? gate_off : {16'h0, vec_entry[15:0]};
    e_ip = wide ? off : {cur_ip[31:16], off[15:0]};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; wcnt = seed % 3; got_done = 0; got_task = 0;
    for (cyc = 0; cyc < 200; cyc++) begin
      if (done) begin got_done = 1; break; end
      if (task_req) begin got_task = 1; break; end
      if (wr_req) begin
        if (disturb && idx == 1) begin
          start = 1'b1; gate_sel = 16'hFFFF; cur_ip = 32'h0; cur_flags = 32'h0;
        end else begin
          start = 1'b0;
        end
        if (wcnt == 0) begin
          if (idx < nexp) begin
            chk(wr_data == ex_data[idx], ex_tag[idx], wr_data, ex_data[idx]);
            chk(wr_addr == ex_addr[idx], "R7 addr", wr_addr, ex_addr[idx]);
            chk(wr_wide == wide, "R7 width", 32'(wr_wide), 32'(wide));
          end else begin
            chk(1'b0, "R6 extra push", 32'(idx), 32'(nexp));
          end
          wr_ack = 1'b1;
          idx++;
          wcnt = (idx + seed) % 3;
        end else begin
          if (idx < nexp)
            chk(wr_addr == ex_addr[idx], "R11 held addr", wr_addr, ex_addr[idx]);
          wr_ack = 1'b0;
          wcnt--;
        end
      end else begin
        wr_ack = 1'b0;
      end
      @(negedge clk);
    end
    wr_ack = 1'b0;
    start = 1'b0;
    if (is_task) begin
      chk(got_task && !got_done, "R2 task_req", 32'(got_task), 32'd1);
      chk(idx == 0, "R2 no pushes", 32'(idx), 32'd0);
    end else begin
      chk(got_done, "R12 done", 32'(got_done), 32'd1);
      chk(idx == nexp, "R6 push count", 32'(idx), 32'(nexp));
      if (disturb)
        chk(new_cs == e_cs, "R1 busy start ignored", 32'(new_cs), 32'(e_cs));
      else
        chk(new_cs == e_cs, p ? "R8 cs" : "R9 cs", 32'(new_cs), 32'(e_cs));
      chk(new_ip == e_ip, "R8 ip", new_ip, e_ip);
      chk(new_ss == e_ss, "R3 ss", 32'(new_ss), 32'(e_ss));
      chk(new_sp == sp, "R7 final sp", new_sp, sp);
      chk(new_cpl == e_cpl, "R3 cpl", 32'(new_cpl), 32'(e_cpl));
      chk(new_if == (is_int ? 1'b0 : fl[9]), "R10 if", 32'(new_if),
          32'(is_int ? 1'b0 : fl[9]));
      chk(segs_null == (p && v), "R4 segs_null", 32'(segs_null), 32'(p && v));
      chk(new_vm == (p ? 1'b0 : v), "R4 vm", 32'(new_vm), 32'(p ? 1'b0 : v));
      @(negedge clk);
      chk(!done && !busy, "R12 single pulse", 32'(done), 32'd0);
    end
  endtask

  initial begin
    int seed;
    logic [3:0] types [5];
    rst_n = 1'b0; start = 1'b0; wr_ack = 1'b0;
    prot_en = 1'b0; vm_flag = 1'b0; err_push = 1'b0; gate_type = '0;
    gate_sel = '0; gate_off = '0; vec_entry = '0; cur_cs = '0; cur_ip = '0;
    cur_flags = '0; cur_ss = '0; cur_sp = '0; cur_cpl = '0;
    seg_gs = '0; seg_fs = '0; seg_ds = '0; seg_es = '0; err_code = '0;
    ring_ss_bus = {16'h0032, 16'h0021, 16'h0010};
    ring_sp_bus = {32'h0000_3000, 32'h0000_2000, 32'h0000_1000};
    types[0] = 4'd6; types[1] = 4'd7; types[2] = 4'd14; types[3] = 4'd15; types[4] = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_req && !done && !task_req, "R12 reset idle",
        {busy, wr_req, done, task_req}, 32'd0);
    seed = 0;
    for (int ti = 0; ti < 5; ti++)
      for (int vv = 0; vv < 2; vv++)
        for (int c = 0; c < 4; c++)
          for (int r = 0; r < 4; r++)
            for (int e = 0; e < 2; e++) begin
              run_frame(1'b1, types[ti], vv[0], c[1:0], r[1:0], e[0],
                        (seed % 2 == 1) ? 32'h0002_0202 : 32'h0000_0046, seed, 1'b0);
              seed++;
            end
    for (int vv = 0; vv < 2; vv++)
      for (int c = 0; c < 4; c++)
        for (int e = 0; e < 2; e++) begin
          run_frame(1'b0, 4'd14, vv[0], c[1:0], 2'd0, e[0], 32'h0000_0202, seed, 1'b0);
          seed++;
        end
    for (int c = 0; c < 4; c++) begin
      run_frame(1'b1, 4'd5, c[0], c[1:0], 2'd1, 1'b1, 32'h0000_0202, seed, 1'b0);
      seed++;
    end
    run_frame(1'b1, 4'd14, 1'b1, 2'd3, 2'd0, 1'b1, 32'h0002_0202, 3, 1'b1);
    run_frame(1'b1, 4'd7, 1'b0, 2'd2, 2'd1, 1'b0, 32'h0000_0202, 4, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule